// File: doc/BRIEF.md
# Instruction Prefix and Interrupt Gate

This unit sits beside the decode stage of a 16-bit processor and keeps the small amount of state that one instruction hands to the instruction right after it. An immediate-prefix instruction leaves twelve upper immediate bits for its successor. An add-with-carry or subtract-with-carry instruction leaves its carry-out so that the following operation can take it as an extra input. Each kind of state lives for exactly one following instruction and is then discarded.

The same unit decides when a single external interrupt line may redirect the program counter to a fixed vector. A prefix or carry pair must never be split, so a request that arrives while such state is live is held. It is taken at the first instruction-retire boundary that leaves no new state behind. When the interrupt is taken, the unit presents the address of the next unexecuted instruction so that the core can save it.

All pins are plain control and data levels that are sampled every cycle. No stream handshake is involved and no back-pressure exists: the retire pulse alone paces the state. Decode and the ALU are outside the block.

Top module: `pfx_irq_gate`

## Requirements
- R1: After reset, no prefix or carry state is live. `carry_in_o` is 0, `irq_take_o` is 0, and `ext_imm_o` is the sign-extended own immediate.
- R2: With no prefix live, `ext_imm_o` equals `own_imm_i` (8 bits) sign-extended to 16 bits.
- R3: When an instruction with `dec_prefix_i`=1 retires, the next instruction sees `ext_imm_o` = {stored 12 prefix bits, `own_imm_i`[3:0]}.
- R4: Prefix state clears on the retire of the consuming instruction. After that, `ext_imm_o` returns to the sign-extended form.
- R5: When an instruction with `dec_carry_i`=1 retires, the `alu_cout_i` of that cycle is stored. The next instruction sees it on `carry_in_o`. The stored value clears on that instruction's retire, and `carry_in_o` is 0 whenever no carry state is live.
- R6: `irq_take_o` is asserted only in a cycle with `retire_i`=1, and never when the retiring instruction itself sets prefix or carry state.
- R7: An interrupt request seen while it cannot be taken is held. It is taken at the first allowed retire, and the held request clears when it is taken.
- R8: In the cycle of `irq_take_o`, `irq_ret_o` equals `pc_next_i`. `irq_vector_o` always shows the fixed vector address (0x0010 by default).
- R9: A prefix that follows a prefix replaces the stored bits. An add/sub-with-carry that consumes a carry stores its own new carry-out.
- R10: Prefix, carry and held-request state change only on a retire pulse. The one exception is a new request, which is captured on any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | Current instruction completes this cycle |
| dec_prefix_i | input | 1 | Current instruction is the immediate prefix |
| dec_carry_i | input | 1 | Current instruction is add/sub with carry |
| prefix_bits_i | input | 12 | Upper immediate bits carried by a prefix |
| own_imm_i | input | 8 | Immediate field of the current instruction |
| alu_cout_i | input | 1 | ALU carry-out of the current instruction |
| irq_i | input | 1 | External interrupt request |
| pc_next_i | input | 16 | Address of the next unexecuted instruction |
| ext_imm_o | output | 16 | Immediate for the current instruction |
| carry_in_o | output | 1 | Saved carry for the current instruction |
| irq_take_o | output | 1 | Redirect to the vector now |
| irq_vector_o | output | 16 | Fixed interrupt vector |
| irq_ret_o | output | 16 | Address to save on interrupt |

## Verification
Two things can fall in one cycle: an interrupt request and the retire of an instruction that opens or closes a pair. The bench raises the request in the same cycle that a prefix retires, and then lets an add-with-carry consume the prefix while it opens a carry window of its own. It judges that `irq_take_o` stays low on both retires and rises only on the retire that closes the chain, with `irq_ret_o` equal to the presented `pc_next_i` in that cycle. A separate case shows a request that arrives on a cycle with no retire, and checks that it is held and taken at the next retire.

// File: rtl/pig_pkg.sv
package pig_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned PFX_W  = 12;
  localparam int unsigned IMM_W  = 8;
  localparam int unsigned LOW_W  = DATA_W - PFX_W;

  typedef struct packed {
    logic prefix;
    logic carry;
  } chain_req_t;
endpackage

// File: rtl/pig_prefix.sv
module pig_prefix #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PFX_W  = 12,
  parameter int unsigned IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire,
  input  logic              set_pfx,
  input  logic [PFX_W-1:0]  pfx_bits,
  input  logic [IMM_W-1:0]  own_imm,
  output logic              live,
  output logic [DATA_W-1:0] ext_imm
);
  localparam int unsigned LOW_W = DATA_W - PFX_W;
  localparam int unsigned EXT_W = DATA_W - IMM_W;

  logic [PFX_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= 1'b0;
      hold_q <= '0;
    end else if (retire) begin
      live <= set_pfx;
      if (set_pfx) hold_q <= pfx_bits;
    end
  end

  always_comb begin
    if (live) ext_imm = {hold_q, own_imm[LOW_W-1:0]};
    else      ext_imm = {{EXT_W{own_imm[IMM_W-1]}}, own_imm};
  end

  AST_PFX_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (live && retire && !set_pfx) |=> !live); // R4
  AST_PFX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(live)); // R10
  AST_PFX_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && set_pfx) |=> live); // R3
endmodule

// File: rtl/pig_carry.sv
module pig_carry (
  input  logic clk,
  input  logic rst_n,
  input  logic retire,
  input  logic set_cy,
  input  logic alu_cout,
  output logic live,
  output logic carry_in
);
  logic val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live  <= 1'b0;
      val_q <= 1'b0;
    end else if (retire) begin
      live  <= set_cy;
      val_q <= set_cy & alu_cout;
    end
  end

  assign carry_in = live & val_q;

  AST_CY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !set_cy) |=> (carry_in == 1'b0)); // R5
  AST_CY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && set_cy) |=> (carry_in == $past(alu_cout))); // R9
  AST_CY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(carry_in)); // R10
endmodule

// File: rtl/pig_irq.sv
module pig_irq #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire,
  input  logic              opens_pair,
  input  logic              irq,
  input  logic [DATA_W-1:0] pc_next,
  output logic              take,
  output logic [DATA_W-1:0] ret_addr
);
  logic pend_q;
  logic want;

  assign want     = pend_q | irq;
  assign take     = retire & want & ~opens_pair;
  assign ret_addr = pc_next;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= want & ~take;
  end

  AST_TAKE_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> retire); // R6
  AST_NO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !opens_pair); // R6
  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take) |=> pend_q); // R7
  AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !pend_q); // R7
endmodule

// File: rtl/pfx_irq_gate.sv
module pfx_irq_gate
  import pig_pkg::*;
#(
  parameter logic [DATA_W-1:0] VEC_ADDR = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic              dec_prefix_i,
  input  logic              dec_carry_i,
  input  logic [PFX_W-1:0]  prefix_bits_i,
  input  logic [IMM_W-1:0]  own_imm_i,
  input  logic              alu_cout_i,
  input  logic              irq_i,
  input  logic [DATA_W-1:0] pc_next_i,
  output logic [DATA_W-1:0] ext_imm_o,
  output logic              carry_in_o,
  output logic              irq_take_o,
  output logic [DATA_W-1:0] irq_vector_o,
  output logic [DATA_W-1:0] irq_ret_o
);
  chain_req_t req;
  logic       pfx_live;
  logic       cy_live;

  assign req.prefix = dec_prefix_i;
  assign req.carry  = dec_carry_i;

  pig_prefix #(.DATA_W(DATA_W), .PFX_W(PFX_W), .IMM_W(IMM_W)) u_prefix (
    .clk(clk), .rst_n(rst_n), .retire(retire_i), .set_pfx(req.prefix),
    .pfx_bits(prefix_bits_i), .own_imm(own_imm_i),
    .live(pfx_live), .ext_imm(ext_imm_o)
  );

  pig_carry u_carry (
    .clk(clk), .rst_n(rst_n), .retire(retire_i), .set_cy(req.carry),
    .alu_cout(alu_cout_i), .live(cy_live), .carry_in(carry_in_o)
  );

  pig_irq #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .retire(retire_i),
    .opens_pair(req.prefix | req.carry), .irq(irq_i), .pc_next(pc_next_i),
    .take(irq_take_o), .ret_addr(irq_ret_o)
  );

  assign irq_vector_o = VEC_ADDR;

  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !(dec_prefix_i || dec_carry_i)) |=> !(pfx_live || cy_live)); // R4
  AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |-> (irq_ret_o == pc_next_i)); // R8
endmodule

// File: tb/test_pfx_irq_gate.sv
module test_pfx_irq_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_i = 1'b0, dec_prefix_i = 1'b0, dec_carry_i = 1'b0;
  logic [11:0] prefix_bits_i = '0;
  logic [7:0]  own_imm_i = '0;
  logic        alu_cout_i = 1'b0, irq_i = 1'b0;
  logic [15:0] pc_next_i = '0;
  logic [15:0] ext_imm_o, irq_vector_o, irq_ret_o;
  logic        carry_in_o, irq_take_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pfx_irq_gate i_pfx_irq_gate (.*);

  typedef struct packed {
    logic        pfx; logic cy; logic [11:0] pb; logic [7:0] imm;
    logic        cout; logic irq; logic ret; logic [15:0] pc;
    logic [15:0] x_imm; logic x_cin; logic x_take;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TAB [NV] = '{
    '{1'b0,1'b0,12'h000,8'hF3,1'b0,1'b0,1'b1,16'h0000,16'hFFF3,1'b0,1'b0}, // R2 negative
    '{1'b0,1'b0,12'h000,8'h7F,1'b0,1'b0,1'b1,16'h0000,16'h007F,1'b0,1'b0}, // R2 positive
    '{1'b1,1'b0,12'hABC,8'h00,1'b0,1'b0,1'b1,16'h0000,16'h0000,1'b0,1'b0}, // prefix retires
    '{1'b0,1'b0,12'h000,8'h5A,1'b0,1'b0,1'b0,16'h0000,16'hABCA,1'b0,1'b0}, // R3 stall, held
    '{1'b0,1'b0,12'h000,8'h01,1'b0,1'b0,1'b1,16'h0000,16'hABC1,1'b0,1'b0}, // R3 consumer
    '{1'b0,1'b0,12'h000,8'h81,1'b0,1'b0,1'b1,16'h0000,16'hFF81,1'b0,1'b0}, // R4 back to sign-ext
    '{1'b0,1'b1,12'h000,8'h00,1'b1,1'b0,1'b1,16'h0000,16'h0000,1'b0,1'b0}, // addc cout=1
    '{1'b0,1'b0,12'h000,8'h00,1'b0,1'b0,1'b1,16'h0000,16'h0000,1'b1,1'b0}, // R5 carry seen
    '{1'b0,1'b0,12'h000,8'h00,1'b0,1'b0,1'b1,16'h0000,16'h0000,1'b0,1'b0}, // R5 cleared
    '{1'b0,1'b0,12'h000,8'h00,1'b0,1'b1,1'b0,16'h0000,16'h0000,1'b0,1'b0}, // R6 irq, no retire
    '{1'b0,1'b0,12'h000,8'h00,1'b0,1'b0,1'b1,16'h1234,16'h0000,1'b0,1'b1}, // R7 held taken
    '{1'b0,1'b0,12'h000,8'h00,1'b0,1'b0,1'b1,16'h0000,16'h0000,1'b0,1'b0}, // R7 pend cleared
    '{1'b1,1'b0,12'h123,8'h00,1'b0,1'b1,1'b1,16'h0000,16'h0000,1'b0,1'b0}, // R6 irq with prefix
    '{1'b0,1'b1,12'h000,8'h02,1'b0,1'b0,1'b1,16'h0000,16'h1232,1'b0,1'b0}, // R6 addc consumes
    '{1'b0,1'b0,12'h000,8'h00,1'b1,1'b0,1'b1,16'h4000,16'h0000,1'b0,1'b1}, // R7 taken at close
    '{1'b0,1'b1,12'h000,8'h00,1'b1,1'b0,1'b1,16'h0000,16'h0000,1'b0,1'b0}, // R9 addc cout=1
    '{1'b0,1'b1,12'h000,8'h00,1'b0,1'b0,1'b1,16'h0000,16'h0000,1'b1,1'b0}, // R9 chain cout=0
    '{1'b0,1'b0,12'h000,8'h00,1'b0,1'b0,1'b1,16'h0000,16'h0000,1'b0,1'b0}, // R9 new carry 0
    '{1'b1,1'b0,12'h0F0,8'h00,1'b0,1'b0,1'b1,16'h0000,16'h0000,1'b0,1'b0}, // prefix A
    '{1'b1,1'b0,12'h00F,8'h03,1'b0,1'b0,1'b1,16'h0000,16'h0F03,1'b0,1'b0}, // R9 prefix B
    '{1'b0,1'b0,12'h000,8'h07,1'b0,1'b0,1'b1,16'h0000,16'h00F7,1'b0,1'b0}  // R9 replaced
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    dec_prefix_i = v.pfx; dec_carry_i = v.cy; prefix_bits_i = v.pb;
    own_imm_i = v.imm; alu_cout_i = v.cout; irq_i = v.irq;
    retire_i = v.ret; pc_next_i = v.pc;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    own_imm_i = 8'h80;
    #2;
    chk("R1 ext_imm", ext_imm_o, 16'hFF80);
    chk("R1 carry_in", {15'd0, carry_in_o}, 16'd0);
    chk("R1 irq_take", {15'd0, irq_take_o}, 16'd0);
    chk("R8 vector", irq_vector_o, 16'h0010);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TAB[i]);
      #2;
      chk($sformatf("row%0d ext_imm R2/R3/R4", i), ext_imm_o, TAB[i].x_imm);
      chk($sformatf("row%0d carry_in R5/R9", i), {15'd0, carry_in_o}, {15'd0, TAB[i].x_cin});
      chk($sformatf("row%0d irq_take R6/R7", i), {15'd0, irq_take_o}, {15'd0, TAB[i].x_take});
      if (TAB[i].x_take)
        chk($sformatf("row%0d R8 ret addr", i), irq_ret_o, TAB[i].pc);
    end

    // R1: reset in the middle of a prefix window discards the prefix
    @(negedge clk);
    drive('{1'b1,1'b0,12'hFFF,8'h00,1'b0,1'b0,1'b1,16'h0,16'h0,1'b0,1'b0});
    @(negedge clk);
    drive('0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    own_imm_i = 8'h12;
    #2;
    chk("R1 prefix cleared by reset", ext_imm_o, 16'h0012);

    // R10: a carry window survives several stall cycles; irq held across them
    @(negedge clk);
    drive('{1'b0,1'b1,12'h0,8'h00,1'b1,1'b0,1'b1,16'h0,16'h0,1'b0,1'b0});
    @(negedge clk);
    drive('0);
    irq_i = 1'b1;
    #2;
    chk("R10 stall, no take", {15'd0, irq_take_o}, 16'd0);
    @(negedge clk);
    irq_i = 1'b0;
    @(negedge clk);
    #2;
    chk("R10 carry still held", {15'd0, carry_in_o}, 16'd1);
    chk("R7 still pending, no retire", {15'd0, irq_take_o}, 16'd0);
    @(negedge clk);
    retire_i = 1'b1;
    pc_next_i = 16'hBEEF;
    #2;
    chk("R7 taken at close of carry window", {15'd0, irq_take_o}, 16'd1);
    chk("R8 ret addr at close", irq_ret_o, 16'hBEEF);
    @(negedge clk);
    #2;
    chk("R5 carry cleared after consumer", {15'd0, carry_in_o}, 16'd0);
    chk("R7 no second take", {15'd0, irq_take_o}, 16'd0);
    retire_i = 1'b0;

    finish_run();
  end
endmodule